// File: doc/BRIEF.md
# Writeback Diff Capture Cache

When an upper-level cache returns a dirty line to an inclusive last-level cache, that cache still holds the previous contents of the line. This block takes both copies and forms their bitwise XOR, which is the change made to the line. It keeps that change in a small, dedicated diff store that is separate from the data array and is indexed by line address. If the same line is written back again while its entry is still present, the new change is XORed into the stored one. The page-checksum update can therefore be postponed until the entry leaves the store, and one update then covers every change collected for that line.

An entry leaves the store in one of two ways. A capture that needs room when the store is full pushes out the oldest entry, or a flush request drains all entries, oldest first. The departing address and accumulated diff are presented on the checksum-update port for one cycle and are then dropped. The diff is never written to memory. In the same cycle, if the last-level cache reports that line dirty, the block raises a write-back-without-invalidate request for it, and the cache then marks the line clean. If the last-level cache no longer holds the old copy, no diff can be formed. The block then asks for the old line to be fetched from memory and leaves the store unchanged.

The controller has two states. ST_IDLE accepts captures. It moves to ST_FLUSH when flush is seen while the store holds at least one entry. ST_FLUSH removes one entry per cycle and returns to ST_IDLE in the cycle that removes the last entry.

Top module: `wbdiff_capture`

## Requirements
- R1: After reset the store is empty, ck_valid, fb_req and clean_req are low, and wb_ready is high.
- R2: An accepted writeback with llc_hit high and an address not in the store records the diff wb_new XOR llc_old in a new entry. No output pulses for it until that entry is removed.
- R3: An accepted writeback with llc_hit high whose address is already stored XORs its diff into that entry. No entry is added and nothing is emitted.
- R4: An accepted writeback with llc_hit low raises fb_req with fb_addr equal to wb_addr one cycle later, and leaves the store unchanged.
- R5: A new-address capture into a full store of ENTRIES entries removes the oldest entry, in insertion order. It emits that entry on ck_valid, ck_addr and ck_diff one cycle after the capture.
- R6: flush in ST_IDLE with a non-empty store starts a drain. Starting one cycle after the next clock edge, one entry is emitted per cycle, oldest first, until the store is empty. A flush with an empty store emits nothing.
- R7: clean_req equals ck_valid AND llc_dirty in the same cycle. llc_dirty reports whether the last-level cache holds ck_addr dirty.
- R8: wb_ready is low while flush is high or a drain is in progress. A writeback offered while wb_ready is low is ignored and changes neither the store nor any output.
- R9: Lookup is fully associative. A match at any stored position merges into that position, and the insertion order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Dirty writeback offered by the upper cache level |
| wb_ready | output | 1 | Writeback is accepted this cycle |
| wb_addr | input | ADDR_W | Line address of the writeback |
| wb_new | input | LINE_W | New line contents |
| llc_hit | input | 1 | Last-level cache holds the old copy |
| llc_old | input | LINE_W | Old line contents from the last-level cache |
| flush | input | 1 | Request to drain every entry |
| fb_req | output | 1 | Old line is missing; fetch it from memory |
| fb_addr | output | ADDR_W | Address for the fallback fetch |
| ck_valid | output | 1 | An entry is leaving toward the page-checksum update |
| ck_addr | output | ADDR_W | Address of the leaving entry |
| ck_diff | output | LINE_W | Accumulated diff of the leaving entry |
| llc_dirty | input | 1 | Last-level cache holds ck_addr dirty |
| clean_req | output | 1 | Write back ck_addr without invalidation and mark it clean |

## Verification
fb_req and the ck port are registered, so each result is due exactly one cycle after the clock edge that samples its cause. For a flush, the first drained entry appears one cycle later still, because the edge that samples flush only changes state. clean_req and wb_ready are combinational on their inputs and are due in the same cycle. The bench drives inputs and advances its reference queue model at the falling edge. It compares the registered outputs at the next falling edge, once the intervening rising edge has updated them. wb_ready is compared shortly after the inputs settle.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } wbd_state_e;
endpackage

// File: rtl/wbd_store.sv
module wbd_store #(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 64,
    parameter int ENTRIES = 4,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [LINE_W-1:0] push_diff,
    input  logic              merge,
    input  logic [IDX_W-1:0]  merge_idx,
    input  logic [LINE_W-1:0] merge_diff,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [IDX_W-1:0]  look_idx,
    output logic [CNT_W-1:0]  fill,
    output logic [ADDR_W-1:0] head_addr,
    output logic [LINE_W-1:0] head_diff
);
    // slot 0 is always the oldest entry; removal shifts toward it
    logic [ADDR_W-1:0] addr_q [ENTRIES];
    logic [LINE_W-1:0] diff_q [ENTRIES];
    logic [ADDR_W-1:0] addr_d [ENTRIES];
    logic [LINE_W-1:0] diff_d [ENTRIES];
    logic [CNT_W-1:0]  fill_d;
    logic [ENTRIES-1:0] slot_eq;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign slot_eq[g] = (CNT_W'(g) < fill) && (addr_q[g] == look_addr);
        end
    endgenerate

    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (slot_eq[i]) begin
                look_hit = 1'b1;
                look_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            addr_d[i] = addr_q[i];
            diff_d[i] = diff_q[i];
        end
        if (merge) begin
            diff_d[merge_idx] = diff_q[merge_idx] ^ merge_diff;
        end
        if (pop) begin
            for (int i = 0; i < ENTRIES - 1; i++) begin
                addr_d[i] = addr_q[i+1];
                diff_d[i] = diff_q[i+1];
            end
        end
        fill_d = fill - CNT_W'(pop);
        if (push) begin
            addr_d[fill_d[IDX_W-1:0]] = push_addr;
            diff_d[fill_d[IDX_W-1:0]] = push_diff;
            fill_d = fill_d + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                addr_q[i] <= '0;
                diff_q[i] <= '0;
            end
        end else begin
            fill <= fill_d;
            for (int i = 0; i < ENTRIES; i++) begin
                addr_q[i] <= addr_d[i];
                diff_q[i] <= diff_d[i];
            end
        end
    end

    assign head_addr = addr_q[0];
    assign head_diff = diff_q[0];

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(ENTRIES));
    p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill == CNT_W'(ENTRIES)) |-> pop);
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill != '0));
    p_merge_no_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (!pop && !push));
endmodule

// File: rtl/wbd_ctrl.sv
module wbd_ctrl
    import wbd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 64,
    parameter int ENTRIES = 4,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [LINE_W-1:0] wb_new,
    input  logic              llc_hit,
    input  logic [LINE_W-1:0] llc_old,
    input  logic              flush,
    input  logic [CNT_W-1:0]  fill,
    input  logic              look_hit,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [LINE_W-1:0] head_diff,
    output logic              wb_ready,
    output logic              pop,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [LINE_W-1:0] push_diff,
    output logic              merge,
    output logic [IDX_W-1:0]  merge_idx,
    output logic [LINE_W-1:0] merge_diff,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [LINE_W-1:0] ev_diff,
    output logic              fb_valid,
    output logic [ADDR_W-1:0] fb_addr
);
    wbd_state_e        state_q, state_d;
    logic              ev_d, fb_d;
    logic [LINE_W-1:0] delta;

    assign delta      = wb_new ^ llc_old;
    assign push_addr  = wb_addr;
    assign push_diff  = delta;
    assign merge_idx  = look_idx;
    assign merge_diff = delta;

    always_comb begin
        state_d  = state_q;
        pop      = 1'b0;
        push     = 1'b0;
        merge    = 1'b0;
        ev_d     = 1'b0;
        fb_d     = 1'b0;
        wb_ready = (state_q == ST_IDLE) && !flush;
        unique case (state_q)
            ST_IDLE: begin
                if (flush) begin
                    if (fill != '0) state_d = ST_FLUSH;
                end else if (wb_valid) begin
                    if (!llc_hit) begin
                        fb_d = 1'b1;
                    end else if (look_hit) begin
                        merge = 1'b1;
                    end else begin
                        push = 1'b1;
                        if (fill == CNT_W'(ENTRIES)) begin
                            pop  = 1'b1;
                            ev_d = 1'b1;
                        end
                    end
                end
            end
            ST_FLUSH: begin
                pop  = 1'b1;
                ev_d = 1'b1;
                if (fill == CNT_W'(1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_addr  <= '0;
            ev_diff  <= '0;
            fb_valid <= 1'b0;
            fb_addr  <= '0;
        end else begin
            ev_valid <= ev_d;
            fb_valid <= fb_d;
            if (ev_d) begin
                ev_addr <= head_addr;
                ev_diff <= head_diff;
            end
            if (fb_d) fb_addr <= wb_addr;
        end
    end

    p_flush_emits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> ev_valid);
    p_excl_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && fb_valid));
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ready && wb_valid && !llc_hit) |=> (fb_valid && $stable(fill)));
    p_capture_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ready && wb_valid && llc_hit && !look_hit && fill != CNT_W'(ENTRIES))
        |=> (fill == $past(fill) + CNT_W'(1)) && !ev_valid);
    p_merge_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ready && wb_valid && llc_hit && look_hit) |=> ($stable(fill) && !ev_valid));
endmodule

// File: rtl/wbdiff_capture.sv
module wbdiff_capture #(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 64,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    output logic              wb_ready,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [LINE_W-1:0] wb_new,
    input  logic              llc_hit,
    input  logic [LINE_W-1:0] llc_old,
    input  logic              flush,
    output logic              fb_req,
    output logic [ADDR_W-1:0] fb_addr,
    output logic              ck_valid,
    output logic [ADDR_W-1:0] ck_addr,
    output logic [LINE_W-1:0] ck_diff,
    input  logic              llc_dirty,
    output logic              clean_req
);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic              pop, push, merge, look_hit;
    logic [ADDR_W-1:0] push_addr, head_addr;
    logic [LINE_W-1:0] push_diff, merge_diff, head_diff;
    logic [IDX_W-1:0]  merge_idx, look_idx;
    logic [CNT_W-1:0]  fill;

    wbd_store #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .pop(pop), .push(push),
        .push_addr(push_addr), .push_diff(push_diff),
        .merge(merge), .merge_idx(merge_idx), .merge_diff(merge_diff),
        .look_addr(wb_addr), .look_hit(look_hit), .look_idx(look_idx),
        .fill(fill), .head_addr(head_addr), .head_diff(head_diff)
    );

    wbd_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .ENTRIES(ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_new(wb_new), .llc_hit(llc_hit), .llc_old(llc_old), .flush(flush),
        .fill(fill), .look_hit(look_hit), .look_idx(look_idx),
        .head_addr(head_addr), .head_diff(head_diff), .wb_ready(wb_ready),
        .pop(pop), .push(push), .push_addr(push_addr), .push_diff(push_diff),
        .merge(merge), .merge_idx(merge_idx), .merge_diff(merge_diff),
        .ev_valid(ck_valid), .ev_addr(ck_addr), .ev_diff(ck_diff),
        .fb_valid(fb_req), .fb_addr(fb_addr)
    );

    // the LLC reports the dirty state of the line currently on ck_addr
    assign clean_req = ck_valid & llc_dirty;

    p_clean_needs_ck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clean_req |-> (ck_valid && llc_dirty));
endmodule

// File: tb/wbdiff_capture_test.sv
`timescale 1ns/1ps
module wbdiff_capture_test;
    localparam int AW = 16;
    localparam int LW = 64;
    localparam int N  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wb_valid = 1'b0, llc_hit = 1'b0, flush = 1'b0, llc_dirty = 1'b0;
    logic [AW-1:0] wb_addr = '0;
    logic [LW-1:0] wb_new = '0, llc_old = '0;
    logic          wb_ready, fb_req, ck_valid, clean_req;
    logic [AW-1:0] fb_addr, ck_addr;
    logic [LW-1:0] ck_diff;

    always #2 clk = ~clk;

    wbdiff_capture #(.ADDR_W(AW), .LINE_W(LW), .ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_new(wb_new), .llc_hit(llc_hit), .llc_old(llc_old),
        .flush(flush), .fb_req(fb_req), .fb_addr(fb_addr), .ck_valid(ck_valid),
        .ck_addr(ck_addr), .ck_diff(ck_diff), .llc_dirty(llc_dirty),
        .clean_req(clean_req)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model
    logic [AW-1:0] m_addr[$];
    logic [LW-1:0] m_diff[$];
    bit            m_drain = 1'b0;
    bit            e_ck = 1'b0, e_fb = 1'b0;
    logic [AW-1:0] e_ck_addr = '0, e_fb_addr = '0;
    logic [LW-1:0] e_ck_diff = '0;

    task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk({tag, " ck_valid"}, LW'(ck_valid), LW'(e_ck));
        chk({tag, " fb_req"},   LW'(fb_req),   LW'(e_fb));
        chk({"R7 clean_req"},   LW'(clean_req), LW'(e_ck & llc_dirty));
        if (e_ck) begin
            chk({tag, " ck_addr"}, LW'(ck_addr), LW'(e_ck_addr));
            chk({tag, " ck_diff"}, ck_diff, e_ck_diff);
        end
        if (e_fb) chk({tag, " R4 fb_addr"}, LW'(fb_addr), LW'(e_fb_addr));
    endtask

    task automatic model_step();
        int idx;
        e_ck = 1'b0;
        e_fb = 1'b0;
        if (m_drain) begin
            e_ck = 1'b1;
            e_ck_addr = m_addr.pop_front();
            e_ck_diff = m_diff.pop_front();
            if (m_addr.size() == 0) m_drain = 1'b0;
        end else if (flush) begin
            if (m_addr.size() != 0) m_drain = 1'b1;
        end else if (wb_valid) begin
            if (!llc_hit) begin
                e_fb = 1'b1;
                e_fb_addr = wb_addr;
            end else begin
                idx = -1;
                foreach (m_addr[k]) if (m_addr[k] == wb_addr && idx < 0) idx = k;
                if (idx >= 0) begin
                    m_diff[idx] = m_diff[idx] ^ (wb_new ^ llc_old);
                end else begin
                    if (m_addr.size() == N) begin
                        e_ck = 1'b1;
                        e_ck_addr = m_addr.pop_front();
                        e_ck_diff = m_diff.pop_front();
                    end
                    m_addr.push_back(wb_addr);
                    m_diff.push_back(wb_new ^ llc_old);
                end
            end
        end
    endtask

    // called at a falling edge: drive, check ready, advance model, wait, compare
    task automatic cyc(bit v, logic [AW-1:0] a, logic [LW-1:0] nw, bit h,
                       logic [LW-1:0] od, bit f, bit d);
        bit exp_rdy;
        wb_valid = v; wb_addr = a; wb_new = nw; llc_hit = h; llc_old = od;
        flush = f; llc_dirty = d;
        exp_rdy = !m_drain && !f;
        #0.5;
        chk({tag, " R8 wb_ready"}, LW'(wb_ready), LW'(exp_rdy));
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0, 0, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        chk("R1 ck_valid", LW'(ck_valid), '0);
        chk("R1 fb_req", LW'(fb_req), '0);
        chk("R1 clean_req", LW'(clean_req), '0);
        chk("R1 wb_ready", LW'(wb_ready), LW'(1));

        tag = "R2";
        cyc(1, 16'h0010, 64'hF0F0_0000_1234_5678, 1, 64'h0F0F_0000_0000_5678, 0, 1);
        idle(1);
        tag = "R3";
        cyc(1, 16'h0010, 64'h0000_0000_0000_00FF, 1, 64'h0000_0000_0000_0F0F, 0, 1);
        tag = "R4";
        cyc(1, 16'h0055, 64'h1, 0, 64'h2, 0, 0);
        tag = "R2";
        cyc(1, 16'h0020, 64'hAAAA, 1, 64'h5555, 0, 0);
        cyc(1, 16'h0030, 64'h1111, 1, 64'h0101, 0, 0);
        cyc(1, 16'h0040, 64'h8000_0000_0000_0000, 1, 64'h0, 0, 0);
        tag = "R9";
        cyc(1, 16'h0030, 64'h00F0, 1, 64'h0000, 0, 0);
        tag = "R5";
        cyc(1, 16'h0050, 64'h7777, 1, 64'h7000, 0, 1);
        idle(1);
        tag = "R7";
        cyc(1, 16'h0060, 64'h3, 1, 64'h0, 0, 0);
        idle(1);
        tag = "R8";
        cyc(1, 16'h0070, 64'h9, 1, 64'h0, 1, 0);
        tag = "R6";
        cyc(1, 16'h0080, 64'h9, 1, 64'h0, 0, 1);
        cyc(1, 16'h0030, 64'h9, 1, 64'h0, 0, 0);
        cyc(1, 16'h0090, 64'h9, 0, 64'h0, 0, 1);
        cyc(0, '0, '0, 0, '0, 0, 1);
        idle(2);
        cyc(0, '0, '0, 0, '0, 1, 1);
        idle(2);

        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 6));
            cyc(($urandom_range(0, 3) != 0), a, {$urandom, $urandom},
                ($urandom_range(0, 7) != 0), {$urandom, $urandom},
                ($urandom_range(0, 24) == 0), $urandom_range(0, 1) == 1);
        end
        idle(8);
        finish_run();
    end
endmodule